// File: doc/BRIEF.md
# Dual-Tone Frequency Classifier

This block turns the two squared-up signals of a touch-tone receiver into a key index. One input carries the low-group tone and the other the high-group tone, each already band-split and hard-limited to one bit. For each band the block counts clock cycles between rising edges. It checks every period against a loose window around each of the four tones of that band. Once it has collected a set number of periods of the same tone, it compares their average with a tighter accept window.

A band is valid once its average lands inside an accept window. It stays valid only while later periods keep matching the same tone. A single stray period, a period outside every window, or a long silence clears it. The flag output is high only while both bands are valid at the same time. The 4-bit index reports which of the 16 tone pairs was recognised last. A synchronous power-down input parks the whole block.

All count limits are computed at elaboration from the clock frequency parameter, so the same RTL serves any clock rate.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: While `rst_n` is low, all state is cleared. After reset, `pair_valid` is 0 and `key_index` is 0.
- R2: When both bands are recognised, `key_index` equals row*4 + col. Row is 0..3 for 697, 770, 852 and 941 Hz; col is 0..3 for 1209, 1336, 1477 and 1633 Hz; row sits in bits [3:2] and col in bits [1:0]. `key_index` does not change while `pair_valid` stays high.
- R3: `pair_valid` is high only while both bands are valid. A tone on only one band never raises it.
- R4: A band becomes valid at the rising edge that closes `AVG_N` consecutive periods of one tone. The edge that starts counting is not one of them. The valid state is visible no earlier than two clock cycles after that edge reaches the input, and no later than three.
- R5: A tone whose average frequency lies within ±(1.5 % + 2 Hz) of nominal is accepted.
- R6: A tone whose average lies outside the accept window is not accepted. This holds both in the gap between the accept window and the ±3.5 % limit and beyond that limit.
- R7: Every period in an averaging set must fall inside the ±3.5 % window of one and the same tone. Periods that alternate between two tones of a band are never accepted.
- R8: While the pair is valid, a single period that fits no tone drops `pair_valid` within three cycles of the edge that ends it. Detection resumes afterwards.
- R9: A band with no rising edge for `HI_GAP_US` (high group) or `LO_GAP_US` (low group) becomes invalid. This drops `pair_valid`.
- R10: While `pwr_down` is high, `pair_valid` is 0. All counters are cleared at the next edge and `key_index` reads 0. After release, detection starts afresh.
- R11: After the tones stop and `pair_valid` falls, `key_index` keeps the last recognised pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down | input | 1 | Synchronous idle request, active high |
| low_sq | input | 1 | Limited low-group tone, asynchronous |
| high_sq | input | 1 | Limited high-group tone, asynchronous |
| pair_valid | output | 1 | Both bands hold a recognised tone |
| key_index | output | 4 | {row, col} of the last recognised pair |

## Verification
The hardest case to reach is an average that fails while every single period passes. This needs a frequency inside the ±3.5 % loose window but outside the ±1.5 % ± 2 Hz accept window. The bench drives a low tone 2.5 % fast to land in that gap. A dropout in the middle of a valid pair is also hard to reach. The bench produces it by waiting for a generated rising edge, shortening exactly the next high-band period to a length no tone accepts, and then restoring the nominal period.

// File: rtl/dtmf_cls_pkg.sv
// Shared constants and elaboration-time helpers for the tone classifier.
// Assumes clock rates below about 9 GHz, so longint arithmetic cannot overflow.
package dtmf_cls_pkg;

    localparam int unsigned TONES = 4;

    // Nominal frequency of tone idx in the chosen band
    function automatic int unsigned tone_hz(input bit high_grp, input int unsigned idx);
        int unsigned f;
        if (high_grp) begin
            case (idx)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end else begin
            case (idx)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end
        return f;
    endfunction

    // Cycle count for frequency f*scale/1000 + off/1000 Hz, rounded down
    function automatic int unsigned period_limit(input longint clk_hz, input int unsigned f_hz,
                                                 input int scale_pm, input int off_mhz);
        longint den;
        den = longint'(f_hz) * longint'(scale_pm) + longint'(off_mhz);
        return int'((clk_hz * 1000) / den);
    endfunction

    // Cycles in a span given in microseconds
    function automatic int unsigned cycles_for_us(input longint clk_hz, input int unsigned us);
        return int'((clk_hz * longint'(us)) / 1000000);
    endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
// Brings an asynchronous limited tone into the clock domain and flags its
// rising edges. Assumes the tone is far slower than the clock.
module dtmf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] shreg;

    // Shift the input through the synchroniser chain plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-1:0], din};
        end
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/dtmf_band_meter.sv
// Measures the period of one band's tone between rising edges and classifies it.
// A first edge arms the meter. Each later edge yields one period, which must fit
// the loose (+-3.5 %) window of a single tone. After AVG_N such periods the summed
// count must sit inside AVG_N times the accept (+-1.5 % +-2 Hz) window. No edge for
// GAP_CYC cycles disarms the band. Assumes GAP_CYC exceeds every loose upper limit.
module dtmf_band_meter #(
    parameter int unsigned CLK_HZ    = 3579545,
    parameter bit          HIGH_GRP  = 1'b0,
    parameter int unsigned AVG_N     = 6,
    parameter int unsigned GAP_CYC   = 14318
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       rise,
    output logic       band_ok,
    output logic [1:0] band_code
);
    import dtmf_cls_pkg::*;

    localparam int CNT_W = $clog2(GAP_CYC + 1);
    localparam int RUN_W = $clog2(AVG_N);
    localparam int SUM_W = CNT_W + $clog2(AVG_N) + 1;

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [RUN_W-1:0] run;
    logic [1:0]       run_idx;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_new;
    logic [TONES-1:0] in_win;
    logic [TONES-1:0] acc_ok;
    logic [1:0]       idx;
    logic             hit, same, last;

    assign sum_new = sum + SUM_W'(cnt);

    // Per-tone window comparators, limits fixed at elaboration
    for (genvar t = 0; t < TONES; t++) begin : g_tone
        localparam int unsigned F_HZ     = tone_hz(HIGH_GRP, t);
        localparam int unsigned LOOSE_LO = period_limit(CLK_HZ, F_HZ, 1035, 0);
        localparam int unsigned LOOSE_HI = period_limit(CLK_HZ, F_HZ, 965, 0);
        localparam int unsigned ACC_LO   = period_limit(CLK_HZ, F_HZ, 1015, 2000);
        localparam int unsigned ACC_HI   = period_limit(CLK_HZ, F_HZ, 985, -2000);
        assign in_win[t] = (cnt >= CNT_W'(LOOSE_LO)) && (cnt <= CNT_W'(LOOSE_HI));
        assign acc_ok[t] = (sum_new >= SUM_W'(AVG_N * ACC_LO)) &&
                           (sum_new <= SUM_W'(AVG_N * ACC_HI));
    end

    // Encode which tone window the current period falls into
    always_comb begin
        idx = 2'd0;
        for (int t = TONES - 1; t >= 0; t--) begin
            if (in_win[t]) idx = 2'(t);
        end
        hit  = |in_win;
        same = (run == '0) ? (!band_ok || idx == band_code) : (idx == run_idx);
        last = (run == RUN_W'(AVG_N - 1));
    end

    // Period counting, set accumulation, verdict and silence timeout
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            armed     <= 1'b0;
            cnt       <= '0;
            run       <= '0;
            run_idx   <= 2'd0;
            sum       <= '0;
            band_ok   <= 1'b0;
            band_code <= 2'd0;
        end else if (rise) begin
            armed <= 1'b1;
            cnt   <= CNT_W'(1);
            if (armed) begin
                if (!hit) begin
                    run     <= '0;
                    sum     <= '0;
                    band_ok <= 1'b0;
                end else if (!same) begin
                    run     <= RUN_W'(1);
                    sum     <= SUM_W'(cnt);
                    run_idx <= idx;
                    band_ok <= 1'b0;
                end else if (last) begin
                    run     <= '0;
                    sum     <= '0;
                    band_ok <= acc_ok[idx];
                    if (acc_ok[idx]) band_code <= idx;
                end else begin
                    run     <= run + RUN_W'(1);
                    sum     <= sum_new;
                    run_idx <= idx;
                end
            end
        end else if (armed) begin
            if (cnt == CNT_W'(GAP_CYC)) begin
                armed   <= 1'b0;
                run     <= '0;
                sum     <= '0;
                band_ok <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtmf_pair_classifier.sv
// Top level: one synchroniser and one period meter per band, combined into a
// pair flag and a {row, col} index. Assumes both inputs are limited square waves.
module dtmf_pair_classifier #(
    parameter int unsigned CLK_HZ    = 3579545,
    parameter int unsigned AVG_N     = 6,
    parameter int unsigned LO_GAP_US = 4000,
    parameter int unsigned HI_GAP_US = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       low_sq,
    input  logic       high_sq,
    output logic       pair_valid,
    output logic [3:0] key_index
);
    import dtmf_cls_pkg::*;

    localparam int unsigned LO_GAP = cycles_for_us(CLK_HZ, LO_GAP_US);
    localparam int unsigned HI_GAP = cycles_for_us(CLK_HZ, HI_GAP_US);

    logic [1:0] band_in;
    logic [1:0] band_rise;
    logic [1:0] band_ok;
    logic [1:0] band_code [2];

    assign band_in = {high_sq, low_sq};

    // One front end per band; index 0 is the low group
    for (genvar g = 0; g < 2; g++) begin : g_band
        dtmf_edge_sync #(.STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (pwr_down),
            .din   (band_in[g]),
            .rise  (band_rise[g])
        );
        dtmf_band_meter #(
            .CLK_HZ   (CLK_HZ),
            .HIGH_GRP (g == 1),
            .AVG_N    (AVG_N),
            .GAP_CYC  ((g == 1) ? HI_GAP : LO_GAP)
        ) u_meter (
            .clk       (clk),
            .rst_n     (rst_n),
            .pwr_down  (pwr_down),
            .rise      (band_rise[g]),
            .band_ok   (band_ok[g]),
            .band_code (band_code[g])
        );
    end

    assign pair_valid = band_ok[0] & band_ok[1] & ~pwr_down;
    assign key_index  = {band_code[0], band_code[1]};

endmodule

// File: rtl/dtmf_pair_checker.sv
// Temporal properties of the classifier, attached to the top level by bind.
module dtmf_pair_checker #(
    parameter int unsigned LO_GAP = 14318
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_down,
    input logic       pair_valid,
    input logic [3:0] key_index,
    input logic       lo_rise,
    input logic       lo_ok
);
    localparam int QW = $clog2(LO_GAP + 2) + 1;
    logic [QW-1:0] quiet;

    // Cycles since the last low-band edge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) quiet <= '0;
        else if (lo_rise) quiet <= QW'(1);
        else if (quiet != '1) quiet <= quiet + QW'(1);
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !pair_valid);

    p_index_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && $past(pair_valid)) |-> $stable(key_index));

    p_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> lo_ok);

    p_rise_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_ok) |-> $past(lo_rise));

    p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ok |-> (quiet <= QW'(LO_GAP)));

    p_idle_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !pair_valid);

endmodule

bind dtmf_pair_classifier dtmf_pair_checker #(.LO_GAP(LO_GAP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .pair_valid (pair_valid),
    .key_index  (key_index),
    .lo_rise    (band_rise[0]),
    .lo_ok      (band_ok[0])
);

// File: tb/dtmf_pair_classifier_tb_top.sv
module dtmf_pair_classifier_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 357954;
    localparam int N          = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic low_sq = 1'b0;
    logic high_sq = 1'b0;
    logic pair_valid;
    logic [3:0] key_index;

    int lo_per = 0, lo_alt = 0, lo_cnt = 0, lo_edges = 0;
    int hi_per = 0, hi_cnt = 0, hi_edges = 0;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dtmf_pair_classifier #(.CLK_HZ(CLK_HZ), .AVG_N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .low_sq(low_sq), .high_sq(high_sq),
        .pair_valid(pair_valid), .key_index(key_index)
    );

    // Low-band square wave, optionally alternating between two periods
    always @(negedge clk) begin
        if (lo_per == 0) begin
            lo_cnt = 0;
            low_sq = 1'b0;
        end else begin
            if (lo_cnt + 1 >= lo_per) begin
                lo_cnt = 0;
                lo_edges++;
                if (lo_alt != 0) begin
                    int tmp;
                    tmp = lo_per; lo_per = lo_alt; lo_alt = tmp;
                end
            end else lo_cnt++;
            low_sq = (lo_cnt < lo_per / 2);
        end
    end

    // High-band square wave
    always @(negedge clk) begin
        if (hi_per == 0) begin
            hi_cnt = 0;
            high_sq = 1'b0;
        end else begin
            if (hi_cnt + 1 >= hi_per) begin
                hi_cnt = 0;
                hi_edges++;
            end else hi_cnt++;
            high_sq = (hi_cnt < hi_per / 2);
        end
    end

    function automatic int freq(input bit hi, input int i);
        int lo_f [4] = '{697, 770, 852, 941};
        int hi_f [4] = '{1209, 1336, 1477, 1633};
        return hi ? hi_f[i] : lo_f[i];
    endfunction

    function automatic int per_of(input bit hi, input int i);
        return (CLK_HZ + freq(hi, i) / 2) / freq(hi, i);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tones(input int lp, input int hp);
        @(posedge clk);
        lo_alt = 0;
        lo_per = lp;
        hi_per = hp;
    endtask

    task automatic silence();
        tones(0, 0);
        repeat (1500) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pair_valid == 1'b0, "R1 flag after reset", pair_valid, 0);
        check(key_index == 4'd0, "R1 index after reset", key_index, 0);
    endtask

    task automatic t_one_band();
        tones(per_of(0, 1), 0);
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b0, "R3 low band only", pair_valid, 0);
        silence();
        tones(0, per_of(1, 2));
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b0, "R3 high band only", pair_valid, 0);
        silence();
    endtask

    task automatic t_latency();
        // Low edges at negedges 1, P, 2P, ...; the band becomes valid after edge 6P
        tones(per_of(0, 0), per_of(1, 0));
        repeat (6 * per_of(0, 0) - 6) @(negedge clk);
        check(pair_valid == 1'b0, "R4 not before N periods", pair_valid, 0);
        repeat (14) @(negedge clk);
        check(pair_valid == 1'b1, "R4 valid after N periods", pair_valid, 1);
        silence();
    endtask

    task automatic t_all_pairs();
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                tones(per_of(0, r), per_of(1, c));
                repeat (3200) @(negedge clk);
                check(pair_valid == 1'b1, "R2 pair flag", pair_valid, 1);
                check(key_index == 4'(r * 4 + c), "R2 pair index", key_index, r * 4 + c);
                silence();
            end
        end
    endtask

    task automatic t_accept_edges();
        // 1.2 % fast low tone with a nominal high tone
        tones(507, per_of(1, 1));
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b1, "R5 fast low tone", pair_valid, 1);
        check(key_index == 4'd1, "R5 fast low index", key_index, 1);
        silence();
        // 1.2 % slow low tone with a 1.2 % fast high tone
        tones(520, 293);
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b1, "R5 skewed pair", pair_valid, 1);
        check(key_index == 4'd0, "R5 skewed index", key_index, 0);
        silence();
    endtask

    task automatic t_reject();
        tones(501, per_of(1, 0));   // 2.5 % fast: in the gap
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b0, "R6 gap tone", pair_valid, 0);
        silence();
        tones(489, per_of(1, 0));   // 5 % fast: beyond the limit
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b0, "R6 far tone", pair_valid, 0);
        silence();
    endtask

    task automatic t_alternating();
        @(posedge clk);
        lo_per = per_of(0, 0);
        lo_alt = per_of(0, 1);
        hi_per = per_of(1, 3);
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b0, "R7 alternating periods", pair_valid, 0);
        silence();
    endtask

    task automatic t_dropout();
        tones(per_of(0, 2), per_of(1, 1));
        repeat (3200) @(negedge clk);
        @(hi_edges);
        check(pair_valid == 1'b1, "R8 valid before dropout", pair_valid, 1);
        hi_per = 150;
        @(hi_edges);
        hi_per = per_of(1, 1);
        repeat (5) @(negedge clk);
        check(pair_valid == 1'b0, "R8 drop after bad period", pair_valid, 0);
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b1, "R8 recovery", pair_valid, 1);
        check(key_index == 4'd9, "R8 recovery index", key_index, 9);
        silence();
    endtask

    task automatic t_gap_and_hold();
        tones(per_of(0, 3), per_of(1, 2));
        repeat (3200) @(negedge clk);
        check(pair_valid == 1'b1, "R9 valid before gap", pair_valid, 1);
        tones(per_of(0, 3), 0);
        repeat (700) @(negedge clk);
        check(pair_valid == 1'b1, "R9 high gap not yet", pair_valid, 1);
        repeat (450) @(negedge clk);
        check(pair_valid == 1'b0, "R9 high gap expired", pair_valid, 0);
        check(key_index == 4'd14, "R11 index held", key_index, 14);
        silence();
        tones(per_of(0, 1), per_of(1, 3));
        repeat (3200) @(negedge clk);
        tones(0, per_of(1, 3));
        repeat (850) @(negedge clk);
        check(pair_valid == 1'b1, "R9 low gap not yet", pair_valid, 1);
        repeat (650) @(negedge clk);
        check(pair_valid == 1'b0, "R9 low gap expired", pair_valid, 0);
        check(key_index == 4'd7, "R11 index held after low gap", key_index, 7);
        silence();
    endtask

    task automatic t_power_down();
        tones(per_of(0, 2), per_of(1, 2));
        repeat (3200) @(negedge clk);
        check(pair_valid == 1'b1, "R10 valid before idle", pair_valid, 1);
        @(posedge clk);
        pwr_down = 1'b1;
        @(negedge clk);
        check(pair_valid == 1'b0, "R10 flag low at once", pair_valid, 0);
        @(negedge clk);
        check(key_index == 4'd0, "R10 index cleared", key_index, 0);
        repeat (4000) @(negedge clk);
        check(pair_valid == 1'b0, "R10 held idle with tones", pair_valid, 0);
        @(posedge clk);
        pwr_down = 1'b0;
        repeat (3500) @(negedge clk);
        check(pair_valid == 1'b1, "R10 resumes after release", pair_valid, 1);
        check(key_index == 4'd10, "R10 index after release", key_index, 10);
        silence();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_one_band();
        t_latency();
        t_all_pairs();
        t_accept_edges();
        t_reject();
        t_alternating();
        t_dropout();
        t_gap_and_hold();
        t_power_down();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule